// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block watches a vector of already-synchronised input pins and turns selected transitions into a single interrupt request for the bank. Every pin has its own trigger selection: rising transitions, falling transitions, both, or none. A detected transition sets a sticky per-pin event bit that stays set until software clears it. A per-pin mask decides which pending events may reach the interrupt line.

Software reaches the block through a simple word-addressed write/read port. There is one control word per pin, plus a status word, a mask word and an unmask word. The status word is cleared by writing ones. The mask word sets mask bits by writing ones. The unmask word clears mask bits by writing ones. Because masking and unmasking use separate words, neither needs a read-modify-write. Only edges are detected; there is no level-sensitive mode.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every mask bit reads 1, every status bit reads 0, every trigger field reads 0 and the interrupt line is low.
- R2: Trigger code 1 latches the pin's status bit on a 0-to-1 change of the pin only; a 1-to-0 change is ignored.
- R3: Trigger code 2 latches the pin's status bit on a 1-to-0 change of the pin only; a 0-to-1 change is ignored.
- R4: Trigger code 3 latches the pin's status bit on either change of the pin.
- R5: Trigger code 0 latches nothing for that pin, whatever the pin does.
- R6: A write to the status word (word address N_PINS) clears every status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R7: A write to the mask word (word address N_PINS+1) sets every mask bit whose write-data bit is 1; bits written with 0 keep their value.
- R8: A write to the unmask word (word address N_PINS+2) clears every mask bit whose write-data bit is 1. Reading either the mask word or the unmask word returns the mask.
- R9: The interrupt line is high exactly when some status bit is set while its mask bit is 0. A transition on the pin becomes visible on the interrupt line one clock after the cycle in which it is presented.
- R10: Masked pins still latch status, so clearing the mask of a pin with a pending event raises the interrupt line in the cycle after the unmask write.
- R11: If a transition that the trigger selects arrives in the same cycle as a status write that clears that pin, the status bit stays set.
- R12: Control word p (word address p) holds the trigger code of pin p in bits 4:3; writes ignore all other bits, and those bits read as 0. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | ADDR_W | Word address for writes and reads |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| pins_i | input | N_PINS | Synchronised pin levels |
| irq_o | output | 1 | Bank interrupt request |

## Verification
Latching a new pin transition and clearing the status bit by software are two functions that can hit the same bit in the same cycle. The bench provokes this by writing ones to the status word while, in that same cycle, it presents a rising edge on a pin set to both edges. The same write also clears a second bit that has no new edge. The status read-back must show that the bit with the fresh edge is still set and that the quiet bit is now clear. The interrupt line is then checked against the mask state.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;

   // Trigger codes held in each pin's control word
   typedef enum logic [1:0] {
      TRIG_NONE = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_BOTH = 2'd3
   } trig_e;

   // Bit position of the trigger field inside a control word
   localparam int TRIG_LSB = 3;
   localparam int TRIG_W   = 2;

   // Register words that follow the per-pin control words
   localparam int OFS_STATUS = 0;
   localparam int OFS_MASK   = 1;
   localparam int OFS_UNMASK = 2;
   localparam int N_EXTRA    = 3;

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
   import gpio_edge_irq_pkg::*;
#(
   parameter int N_PINS = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_PINS-1:0]              pins_i,
   input  logic [N_PINS-1:0][TRIG_W-1:0]  trig_i,
   output logic [N_PINS-1:0]              hit_o
);

   logic [N_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins_i;
   end

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      logic rise, fall, rise_en, fall_en;
      assign rise     = pins_i[p] & ~prev_q[p];
      assign fall     = ~pins_i[p] & prev_q[p];
      assign rise_en  = (trig_i[p] == TRIG_RISE) || (trig_i[p] == TRIG_BOTH);
      assign fall_en  = (trig_i[p] == TRIG_FALL) || (trig_i[p] == TRIG_BOTH);
      assign hit_o[p] = (rise & rise_en) | (fall & fall_en);
   end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_edge_irq_pkg::*;
#(
   parameter int N_PINS = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_wr_i,
   input  logic [ADDR_W-1:0]              bus_addr_i,
   input  logic [DATA_W-1:0]              bus_wdata_i,
   output logic [DATA_W-1:0]              bus_rdata_o,
   input  logic [N_PINS-1:0]              hit_i,
   output logic [N_PINS-1:0][TRIG_W-1:0]  trig_o,
   output logic [N_PINS-1:0]              status_o,
   output logic [N_PINS-1:0]              mask_o
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(N_PINS + OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(N_PINS + OFS_MASK);
   localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(N_PINS + OFS_UNMASK);

   logic [N_PINS-1:0][TRIG_W-1:0] trig_q;
   logic [N_PINS-1:0]             status_q;
   logic [N_PINS-1:0]             mask_q;
   logic [N_PINS-1:0]             wr_bits;
   logic                          wr_status, wr_mask, wr_unmask;

   assign wr_bits   = bus_wdata_i[N_PINS-1:0];
   assign wr_status = bus_wr_i && (bus_addr_i == A_STATUS);
   assign wr_mask   = bus_wr_i && (bus_addr_i == A_MASK);
   assign wr_unmask = bus_wr_i && (bus_addr_i == A_UNMASK);

   // Per-pin trigger fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= '0;
      end else if (bus_wr_i) begin
         for (int p = 0; p < N_PINS; p++) begin
            if (bus_addr_i == ADDR_W'(p))
               trig_q[p] <= bus_wdata_i[TRIG_LSB +: TRIG_W];
         end
      end
   end

   // Sticky events: a fresh hit outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~(wr_status ? wr_bits : '0)) | hit_i;
   end

   // Mask: separate set and clear words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '1;
      else if (wr_mask)   mask_q <= mask_q | wr_bits;
      else if (wr_unmask) mask_q <= mask_q & ~wr_bits;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == A_STATUS) begin
         bus_rdata_o[N_PINS-1:0] = status_q;
      end else if ((bus_addr_i == A_MASK) || (bus_addr_i == A_UNMASK)) begin
         bus_rdata_o[N_PINS-1:0] = mask_q;
      end else begin
         for (int p = 0; p < N_PINS; p++) begin
            if (bus_addr_i == ADDR_W'(p))
               bus_rdata_o[TRIG_LSB +: TRIG_W] = trig_q[p];
         end
      end
   end

   assign trig_o   = trig_q;
   assign status_o = status_q;
   assign mask_o   = mask_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
   parameter int N_PINS = 32
) (
   input  logic [N_PINS-1:0] status_i,
   input  logic [N_PINS-1:0] mask_i,
   output logic              irq_o
);

   assign irq_o = |(status_i & ~mask_i);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gpio_edge_irq_pkg::*;
#(
   parameter int N_PINS = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [N_PINS-1:0] pins_i,
   output logic              irq_o
);

   localparam int N_WORDS = N_PINS + N_EXTRA;

   if (N_PINS < 1 || N_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_edge_irq: N_PINS must lie in 1..DATA_W");
   end
   if (DATA_W < TRIG_LSB + TRIG_W) begin : g_bad_width
      $error("gpio_edge_irq: DATA_W too narrow for the trigger field");
   end
   if ((2 ** ADDR_W) < N_WORDS) begin : g_bad_addr
      $error("gpio_edge_irq: ADDR_W cannot reach every register word");
   end

   logic [N_PINS-1:0][TRIG_W-1:0] trig_w;
   logic [N_PINS-1:0]             hit_w;
   logic [N_PINS-1:0]             status_w;
   logic [N_PINS-1:0]             mask_w;

   gpio_edge_detect #(.N_PINS(N_PINS)) i_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (pins_i),
      .trig_i (trig_w),
      .hit_o  (hit_w)
   );

   gpio_irq_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .hit_i       (hit_w),
      .trig_o      (trig_w),
      .status_o    (status_w),
      .mask_o      (mask_w)
   );

   gpio_irq_combine #(.N_PINS(N_PINS)) i_combine (
      .status_i (status_w),
      .mask_i   (mask_w),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
   import gpio_edge_irq_pkg::*;
#(
   parameter int N_PINS = 32,
   parameter int ADDR_W = 6
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_wr_i,
   input logic [ADDR_W-1:0]              bus_addr_i,
   input logic [N_PINS-1:0]              wbits_i,
   input logic [N_PINS-1:0]              hit_i,
   input logic [N_PINS-1:0][TRIG_W-1:0]  trig_i,
   input logic [N_PINS-1:0]              status_i,
   input logic [N_PINS-1:0]              mask_i,
   input logic                           irq_i
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(N_PINS + OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(N_PINS + OFS_MASK);
   localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(N_PINS + OFS_UNMASK);

   logic w_stat, w_mask, w_unmask;
   assign w_stat   = bus_wr_i && (bus_addr_i == A_STATUS);
   assign w_mask   = bus_wr_i && (bus_addr_i == A_MASK);
   assign w_unmask = bus_wr_i && (bus_addr_i == A_UNMASK);

   // R6: cleared bits without a fresh hit read 0 next cycle
   p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      w_stat |=> (status_i & $past(wbits_i & ~hit_i)) == '0);

   // R11: a hit always lands, even against a clear
   p_hit_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i != '0) |=> (status_i & $past(hit_i)) == $past(hit_i));

   // R7: written ones appear in the mask
   p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      w_mask |=> (mask_i & $past(wbits_i)) == $past(wbits_i));

   // R8: unmask ones leave the mask
   p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      w_unmask |=> (mask_i & $past(wbits_i)) == '0);

   // R7: the mask only moves on its own two words
   p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_mask || w_unmask) |=> $stable(mask_i));

   // R9: an unmasked hit raises the line next cycle
   p_irq_after_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit_i & ~mask_i) != '0) && !w_mask |=> irq_i);

   // R9: no pending event, no request
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_i == '0) |-> !irq_i);

   // R5: a disabled pin never produces a hit
   for (genvar p = 0; p < N_PINS; p++) begin : g_off
      p_trig_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_i[p] == TRIG_NONE) |-> !hit_i[p]);
   end

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr_i   (bus_wr_i),
   .bus_addr_i (bus_addr_i),
   .wbits_i    (bus_wdata_i[N_PINS-1:0]),
   .hit_i      (hit_w),
   .trig_i     (trig_w),
   .status_i   (status_w),
   .mask_i     (mask_w),
   .irq_i      (irq_o)
);

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;

   localparam int CLK_PERIOD = 10;
   localparam int N_PINS     = 32;
   localparam int DATA_W     = 32;
   localparam int ADDR_W     = 6;
   localparam int WATCHDOG   = 20000;

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(N_PINS);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(N_PINS + 1);
   localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(N_PINS + 2);

   logic              clk;
   logic              rst_n;
   logic              bus_wr;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic [N_PINS-1:0] pins;
   logic              irq;

   gpio_edge_irq #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_gpio_edge_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .pins_i      (pins),
      .irq_o       (irq)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   logic  mon_req;
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   // Monitor: pops one expectation per request, away from the active edge
   always @(negedge clk) begin
      if (mon_req) begin
         item_t       it;
         logic [31:0] act;
         n_chk++;
         if (q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual empty queue expected one item");
         end else begin
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      tick();
      bus_wr    = 1'b0;
   endtask

   task automatic expect_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
      item_t it;
      bus_addr  = a;
      it.is_irq = 1'b0;
      it.exp    = e;
      it.tag    = tag;
      q.push_back(it);
      mon_req   = 1'b1;
      tick();
      mon_req   = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      it.is_irq = 1'b1;
      it.exp    = {31'b0, e};
      it.tag    = tag;
      q.push_back(it);
      mon_req   = 1'b1;
      tick();
      mon_req   = 1'b0;
   endtask

   task automatic drive_pins(input logic [N_PINS-1:0] v);
      pins = v;
      tick();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      bus_wr    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      pins      = '0;
      mon_req   = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      expect_read(A_MASK,   32'hFFFF_FFFF, "R1 mask after reset");
      expect_read(A_STATUS, 32'h0,         "R1 status after reset");
      expect_read(6'd0,     32'h0,         "R1 trigger after reset");
      expect_irq(1'b0, "R1 irq after reset");

      // R12: trigger field in bits 4:3
      bus_write(6'd0, 32'h0000_0008);   // pin0 rising
      bus_write(6'd1, 32'h0000_0010);   // pin1 falling
      bus_write(6'd2, 32'h0000_0018);   // pin2 both
      bus_write(6'd3, 32'hFFFF_FFE7);   // pin3 off, other bits set
      bus_write(6'd4, 32'hFFFF_FFFF);   // pin4 both
      expect_read(6'd4, 32'h0000_0018, "R12 other bits dropped");
      expect_read(6'd1, 32'h0000_0010, "R12 falling code readback");
      expect_read(6'd3, 32'h0,         "R12 code 0 readback");
      expect_read(6'd40, 32'h0,        "R12 unused address");

      // R2 R4 R5: rising on pins 0..3
      drive_pins(32'h0000_000F);
      expect_read(A_STATUS, 32'h0000_0005, "R2 R3 R4 R5 rising pattern");
      expect_irq(1'b0, "R10 masked events keep irq low");

      // R6: clear all latched
      bus_write(A_STATUS, 32'h0000_0005);
      expect_read(A_STATUS, 32'h0, "R6 full clear");

      // R3 R4: falling on pins 0..3
      drive_pins(32'h0);
      expect_read(A_STATUS, 32'h0000_0006, "R2 R3 R4 falling pattern");
      bus_write(A_STATUS, 32'h0000_0002);
      expect_read(A_STATUS, 32'h0000_0004, "R6 partial clear");

      // R8 R10: unmask a pending pin
      bus_write(A_UNMASK, 32'h0000_0004);
      expect_irq(1'b1, "R10 unmask pending raises irq");
      expect_read(A_MASK,   32'hFFFF_FFFB, "R8 unmask clears bit");
      expect_read(A_UNMASK, 32'hFFFF_FFFB, "R8 unmask word reads mask");

      // R7: zeros do nothing, ones set
      bus_write(A_MASK, 32'h0);
      expect_read(A_MASK, 32'hFFFF_FFFB, "R7 zero write keeps mask");
      bus_write(A_MASK, 32'h0000_0004);
      expect_read(A_MASK, 32'hFFFF_FFFF, "R7 one sets mask");
      expect_irq(1'b0, "R7 mask drops irq");

      // R9: latency from pin to irq
      bus_write(A_UNMASK, 32'h0000_0001);
      expect_irq(1'b0, "R9 unmasked idle pin keeps irq low");
      pins = 32'h0000_0001;
      expect_irq(1'b0, "R9 irq low in edge cycle");
      expect_irq(1'b1, "R9 irq high one cycle later");
      expect_read(A_STATUS, 32'h0000_0005, "R2 rising latched unmasked");

      // R11: edge on pin2 and clear of pins 0,2 in the same cycle
      pins      = 32'h0000_0005;
      bus_write(A_STATUS, 32'h0000_0005);
      expect_read(A_STATUS, 32'h0000_0004, "R11 fresh edge survives clear");
      expect_irq(1'b0, "R9 only masked event pending");

      // R2 on the top pin, R9 with everything unmasked
      bus_write(6'd31, 32'h0000_0008);
      drive_pins(32'h8000_0005);
      expect_read(A_STATUS, 32'h8000_0004, "R2 top pin rising");
      bus_write(A_UNMASK, 32'hFFFF_FFFF);
      expect_read(A_MASK, 32'h0, "R8 unmask all");
      expect_irq(1'b1, "R9 irq with unmasked pending");
      bus_write(A_STATUS, 32'hFFFF_FFFF);
      expect_read(A_STATUS, 32'h0, "R6 clear all");
      expect_irq(1'b0, "R9 irq after clear all");

      // R5: code-0 pin toggles while unmasked
      drive_pins(32'h8000_000D);
      drive_pins(32'h8000_0005);
      expect_read(A_STATUS, 32'h0, "R5 disabled pin ignored");
      expect_irq(1'b0, "R5 no irq from disabled pin");

      // R4: both-edge pin4
      drive_pins(32'h8000_0015);
      expect_read(A_STATUS, 32'h0000_0010, "R4 both edges rising");
      bus_write(A_STATUS, 32'h0000_0010);
      drive_pins(32'h8000_0005);
      expect_read(A_STATUS, 32'h0000_0010, "R4 both edges falling");
      expect_irq(1'b1, "R9 irq from pin4");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule